// File: doc/BRIEF.md
# Paged MMU with Task Maps

This block sits between an 8-bit CPU with a 64 KB logical address space and a much larger physical memory. The logical space is cut into eight 8 KB slots. The three top address bits select a slot, and that slot is looked up in the map of the currently running task. The result is a 14-bit physical page number. Map storage holds 32 tasks of eight entries each. Every entry carries a page number, a read-only flag and one spare protection bit. Software programs the map, the running task and a small control word through registers in the always-present I/O page at `$FFxx`.

Eight physical pages form a window onto the 64 KB motherboard memory. An access that lands in that window selects the motherboard bus, and any other access selects local memory. Writes aimed at local memory are shown to the motherboard as reads, so motherboard RAM is never disturbed by them. Writes to a read-only page change no memory. They latch a violation flag, which drives a level interrupt when the interrupt is enabled. The I/O page is never translated. The page at `$FExx` can be made common to every task by a control bit. Translation is purely combinational, and all map and control state is held in registers.

Top module: `task_page_mmu`

## Requirements
- R1: After reset the active task is 0, the edit pointer is 0, the control and status registers read 0, `irq` is low, and slot s of task 0 maps to physical page `$38`+s (readable back with high byte 0).
- R2: For a translated access, `phys_page` equals the 14-bit page stored in entry `cpu_addr[15:13]` of the active task.
- R3: Map entries of the task named by the edit pointer (`$FF41`, 5 bits) are reached at `$FF50`+2s (page bits 7:0) and `$FF51`+2s (bits 5:0 = page bits 13:8, bit 6 = read-only, bit 7 = spare, stored and read back). While such a register is accessed, `reg_sel` is high and `cpu_rdata` returns the stored byte.
- R4: The active task register at `$FF40` holds 5 bits and selects one of 32 independent maps. Unused written bits read back as 0.
- R5: During `cpu_valid`, exactly one of `mb_cs` and `local_cs` is high: `mb_cs` when the physical page is `$38`..`$3F`, otherwise `local_cs`. Both are low without `cpu_valid`.
- R6: `mb_read` is low only for a permitted write to a motherboard page. A write to local memory drives `local_write` high and keeps `mb_read` high.
- R7: A write to a translated page whose read-only bit is set keeps `local_write` low and `mb_read` high. Reads of such a page proceed normally.
- R8: A read-only write sets status bit 0 at `$FF43`. Writing 1 to that bit clears it, and writing 0 leaves it unchanged. Reads never set it. `irq` is high while the flag is set and control bit 1 at `$FF42` is 1.
- R9: Accesses to `$FFxx` are never translated. They go to physical page `$3F` on the motherboard in every task, writes included, and are never read-only.
- R10: With control bit 0 at `$FF42` set, `$FExx` goes to physical page `$3F` on the motherboard without protection. With the bit clear, `$FExx` is translated through slot 7 like the rest of the slot.
- R11: The task, edit-pointer and control registers read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | CPU access strobe; a write is taken only while it is high |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 16 | CPU logical address |
| cpu_wdata | input | 8 | CPU write data for the MMU registers |
| cpu_rdata | output | 8 | Register read data, valid while `reg_sel` is high |
| reg_sel | output | 1 | An MMU register is addressed |
| phys_page | output | 14 | Physical page number of the current access |
| local_cs | output | 1 | Local memory is selected |
| mb_cs | output | 1 | Motherboard bus is selected |
| mb_read | output | 1 | Read/write qualifier shown to the motherboard (1 = read) |
| local_write | output | 1 | Write enable for local memory |
| irq | output | 1 | Protection-violation interrupt, level |

## Verification
The assertions check on every cycle that the two chip selects are mutually exclusive and idle without a strobe, and that the motherboard sees a write only for a motherboard page. They also check that a protection violation blocks both write paths, that reads never raise a violation, that the violation flag latches and holds until a register write, and that the I/O page always lands on the fixed motherboard page. Only the directed scenarios can show the values involved. These are the reset identity map, the page numbers read back and translated for programmed tasks, the independence of tasks, the effect of the common-page bit in both states, and the set and clear sequence of the interrupt.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  // Register offsets inside the I/O page
  localparam logic [7:0] OFF_TASK = 8'h40;
  localparam logic [7:0] OFF_EDIT = 8'h41;
  localparam logic [7:0] OFF_CTRL = 8'h42;
  localparam logic [7:0] OFF_STAT = 8'h43;
  localparam logic [3:0] MAP_NIB  = 4'h5;

  // Control and status bit positions
  localparam int CTRL_COMMON = 0;
  localparam int CTRL_IRQEN  = 1;
  localparam int STAT_VIOL   = 0;

  // High byte of an entry
  localparam int HI_RO    = 6;
  localparam int HI_SPARE = 7;

  localparam logic [7:0] IO_PAGE     = 8'hFF;
  localparam logic [7:0] COMMON_PAGE = 8'hFE;
endpackage

// File: rtl/mmu_map_store.sv
module mmu_map_store #(
  parameter int TASK_W   = 5,
  parameter int SLOT_W   = 3,
  parameter int PAGE_W   = 14,
  parameter int MB_BASE  = 56
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [TASK_W-1:0] wr_task,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [7:0]        wr_data,
  input  logic [TASK_W-1:0] xl_task,
  input  logic [SLOT_W-1:0] xl_slot,
  output logic [7:0]        xl_lo,
  output logic [7:0]        xl_hi,
  input  logic [TASK_W-1:0] cfg_task,
  input  logic [SLOT_W-1:0] cfg_slot,
  output logic [7:0]        cfg_lo,
  output logic [7:0]        cfg_hi
);
  localparam int AW     = TASK_W + SLOT_W;
  localparam int DEPTH  = 1 << AW;
  localparam int NSLOT  = 1 << SLOT_W;
  localparam logic [PAGE_W-1:0] BASE_PG = PAGE_W'(MB_BASE);

  // Storage without reset so it can map onto distributed RAM
  logic [7:0] mem_lo [DEPTH];
  logic [7:0] mem_hi [DEPTH];

  // Task 0 bytes not yet written return the identity default
  logic [NSLOT-1:0] t0_lo_set;
  logic [NSLOT-1:0] t0_hi_set;

  logic [AW-1:0] wr_idx;
  assign wr_idx = {wr_task, wr_slot};

  always_ff @(posedge clk) begin
    if (wr_en && !wr_hi) mem_lo[wr_idx] <= wr_data;
    if (wr_en &&  wr_hi) mem_hi[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      t0_lo_set <= '0;
      t0_hi_set <= '0;
    end else if (wr_en && wr_task == '0) begin
      if (wr_hi) t0_hi_set[wr_slot] <= 1'b1;
      else       t0_lo_set[wr_slot] <= 1'b1;
    end
  end

  function automatic logic [PAGE_W-1:0] dflt_page(input logic [SLOT_W-1:0] s);
    return BASE_PG + PAGE_W'(s);
  endfunction

  function automatic logic [7:0] pick_lo(input logic [TASK_W-1:0] t,
                                         input logic [SLOT_W-1:0] s,
                                         input logic [NSLOT-1:0] set_v,
                                         input logic [7:0] stored);
    logic [PAGE_W-1:0] p;
    p = dflt_page(s);
    if (t == '0 && !set_v[s]) return p[7:0];
    return stored;
  endfunction

  function automatic logic [7:0] pick_hi(input logic [TASK_W-1:0] t,
                                         input logic [SLOT_W-1:0] s,
                                         input logic [NSLOT-1:0] set_v,
                                         input logic [7:0] stored);
    logic [PAGE_W-1:0] p;
    p = dflt_page(s);
    if (t == '0 && !set_v[s]) return 8'(p[PAGE_W-1:8]);
    return stored;
  endfunction

  always_comb begin
    xl_lo  = pick_lo(xl_task,  xl_slot,  t0_lo_set, mem_lo[{xl_task, xl_slot}]);
    xl_hi  = pick_hi(xl_task,  xl_slot,  t0_hi_set, mem_hi[{xl_task, xl_slot}]);
    cfg_lo = pick_lo(cfg_task, cfg_slot, t0_lo_set, mem_lo[{cfg_task, cfg_slot}]);
    cfg_hi = pick_hi(cfg_task, cfg_slot, t0_hi_set, mem_hi[{cfg_task, cfg_slot}]);
  end
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_pkg::*;
#(
  parameter int PAGE_W   = 14,
  parameter int MB_BASE  = 56,
  parameter int MB_PAGES = 8
) (
  input  logic              cpu_valid,
  input  logic              cpu_rw,
  input  logic [7:0]        addr_hi,
  input  logic [7:0]        entry_lo,
  input  logic [7:0]        entry_hi,
  input  logic              common_en,
  output logic [PAGE_W-1:0] phys_page,
  output logic              local_cs,
  output logic              mb_cs,
  output logic              mb_read,
  output logic              local_write,
  output logic              wp_violation
);
  localparam int HI_W = PAGE_W - 8;
  localparam logic [PAGE_W-1:0] MB_LO = PAGE_W'(MB_BASE);
  localparam logic [PAGE_W-1:0] MB_HI = PAGE_W'(MB_BASE + MB_PAGES - 1);

  logic              fixed_pg;
  logic              is_mb;
  logic              is_wr;
  logic [PAGE_W-1:0] xl_page;

  always_comb begin
    fixed_pg     = (addr_hi == IO_PAGE) || (common_en && addr_hi == COMMON_PAGE);
    xl_page      = {entry_hi[HI_W-1:0], entry_lo};
    phys_page    = fixed_pg ? MB_HI : xl_page;
    is_mb        = (phys_page >= MB_LO) && (phys_page <= MB_HI);
    is_wr        = cpu_valid && !cpu_rw;
    wp_violation = is_wr && !fixed_pg && entry_hi[HI_RO];
    local_cs     = cpu_valid && !is_mb;
    mb_cs        = cpu_valid && is_mb;
    local_write  = is_wr && !is_mb && !wp_violation;
    mb_read      = !(is_wr && is_mb && !wp_violation);
  end
endmodule

// File: rtl/mmu_regs.sv
module mmu_regs
  import mmu_pkg::*;
#(
  parameter int TASK_W = 5,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_rw,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic [7:0]        cfg_lo,
  input  logic [7:0]        cfg_hi,
  input  logic              wp_violation,
  output logic [TASK_W-1:0] active_task,
  output logic [TASK_W-1:0] edit_task,
  output logic              map_wr_en,
  output logic              map_wr_hi,
  output logic [SLOT_W-1:0] map_wr_slot,
  output logic              common_en,
  output logic              irq_en,
  output logic              viol_flag,
  output logic              irq,
  output logic              reg_sel,
  output logic              reg_wr,
  output logic [7:0]        cpu_rdata
);
  logic io_hit, ctl_hit, map_hit, wr;
  logic [TASK_W-1:0] task_n, edit_n;
  logic common_n, irq_en_n, flag_n;

  always_comb begin
    io_hit      = cpu_addr[15:8] == IO_PAGE;
    ctl_hit     = io_hit && (cpu_addr[7:2] == OFF_TASK[7:2]);
    map_hit     = io_hit && (cpu_addr[7:4] == MAP_NIB);
    reg_sel     = cpu_valid && (ctl_hit || map_hit);
    wr          = cpu_valid && !cpu_rw;
    reg_wr      = reg_sel && !cpu_rw;
    map_wr_en   = wr && map_hit;
    map_wr_hi   = cpu_addr[0];
    map_wr_slot = cpu_addr[SLOT_W:1];
  end

  always_comb begin
    task_n   = active_task;
    edit_n   = edit_task;
    common_n = common_en;
    irq_en_n = irq_en;
    flag_n   = viol_flag;
    if (wr && ctl_hit) begin
      unique case (cpu_addr[7:0])
        OFF_TASK: task_n = cpu_wdata[TASK_W-1:0];
        OFF_EDIT: edit_n = cpu_wdata[TASK_W-1:0];
        OFF_CTRL: begin
          common_n = cpu_wdata[CTRL_COMMON];
          irq_en_n = cpu_wdata[CTRL_IRQEN];
        end
        OFF_STAT: if (cpu_wdata[STAT_VIOL]) flag_n = 1'b0;
        default: ;
      endcase
    end
    // A new violation wins over a clear in the same cycle
    if (wp_violation) flag_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_task <= '0;
      edit_task   <= '0;
      common_en   <= 1'b0;
      irq_en      <= 1'b0;
      viol_flag   <= 1'b0;
      irq         <= 1'b0;
    end else begin
      active_task <= task_n;
      edit_task   <= edit_n;
      common_en   <= common_n;
      irq_en      <= irq_en_n;
      viol_flag   <= flag_n;
      irq         <= flag_n && irq_en_n;
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (map_hit) begin
      cpu_rdata = cpu_addr[0] ? cfg_hi : cfg_lo;
    end else if (ctl_hit) begin
      unique case (cpu_addr[1:0])
        2'd0: cpu_rdata[TASK_W-1:0] = active_task;
        2'd1: cpu_rdata[TASK_W-1:0] = edit_task;
        2'd2: begin
          cpu_rdata[CTRL_COMMON] = common_en;
          cpu_rdata[CTRL_IRQEN]  = irq_en;
        end
        default: cpu_rdata[STAT_VIOL] = viol_flag;
      endcase
    end
  end
endmodule

// File: rtl/task_page_mmu.sv
module task_page_mmu #(
  parameter int TASK_W    = 5,
  parameter int PAGE_W    = 14,
  parameter int MB_BASE   = 56,
  parameter int MB_PAGES  = 8,
  parameter int PG_SHIFT  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_rw,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              reg_sel,
  output logic [PAGE_W-1:0] phys_page,
  output logic              local_cs,
  output logic              mb_cs,
  output logic              mb_read,
  output logic              local_write,
  output logic              irq
);
  localparam int SLOT_W = 16 - PG_SHIFT;

  logic [TASK_W-1:0] active_task, edit_task;
  logic [7:0]        xl_lo, xl_hi, cfg_lo, cfg_hi;
  logic              map_wr_en, map_wr_hi;
  logic [SLOT_W-1:0] map_wr_slot;
  logic              common_en, irq_en, viol_flag, wp_violation, reg_wr;

  mmu_regs #(.TASK_W(TASK_W), .SLOT_W(SLOT_W)) u_regs (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_rw(cpu_rw), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .wp_violation(wp_violation),
    .active_task(active_task), .edit_task(edit_task),
    .map_wr_en(map_wr_en), .map_wr_hi(map_wr_hi), .map_wr_slot(map_wr_slot),
    .common_en(common_en), .irq_en(irq_en), .viol_flag(viol_flag), .irq(irq),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .cpu_rdata(cpu_rdata)
  );

  mmu_map_store #(.TASK_W(TASK_W), .SLOT_W(SLOT_W), .PAGE_W(PAGE_W), .MB_BASE(MB_BASE)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(map_wr_en), .wr_hi(map_wr_hi), .wr_task(edit_task), .wr_slot(map_wr_slot),
    .wr_data(cpu_wdata),
    .xl_task(active_task), .xl_slot(cpu_addr[15 -: SLOT_W]), .xl_lo(xl_lo), .xl_hi(xl_hi),
    .cfg_task(edit_task), .cfg_slot(cpu_addr[SLOT_W:1]), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi)
  );

  mmu_xlate #(.PAGE_W(PAGE_W), .MB_BASE(MB_BASE), .MB_PAGES(MB_PAGES)) u_xlate (
    .cpu_valid(cpu_valid), .cpu_rw(cpu_rw), .addr_hi(cpu_addr[15:8]),
    .entry_lo(xl_lo), .entry_hi(xl_hi), .common_en(common_en),
    .phys_page(phys_page), .local_cs(local_cs), .mb_cs(mb_cs), .mb_read(mb_read),
    .local_write(local_write), .wp_violation(wp_violation)
  );
endmodule

// File: rtl/mmu_checker.sv
module mmu_checker #(
  parameter int PAGE_W   = 14,
  parameter int MB_BASE  = 56,
  parameter int MB_PAGES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_valid,
  input logic              cpu_rw,
  input logic [15:0]       cpu_addr,
  input logic [PAGE_W-1:0] phys_page,
  input logic              local_cs,
  input logic              mb_cs,
  input logic              mb_read,
  input logic              local_write,
  input logic              viol_flag,
  input logic              wp_violation,
  input logic              reg_wr
);
  localparam logic [PAGE_W-1:0] TOP_PG = PAGE_W'(MB_BASE + MB_PAGES - 1);

  assert_cs_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(local_cs && mb_cs));

  assert_cs_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !cpu_valid |-> (!local_cs && !mb_cs));

  assert_mb_write_target_R6: assert property (@(posedge clk) disable iff (rst)
    !mb_read |-> (mb_cs && !cpu_rw));

  assert_ro_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    wp_violation |-> (!local_write && mb_read));

  assert_read_no_viol_R8: assert property (@(posedge clk) disable iff (rst)
    cpu_rw |-> !wp_violation);

  assert_viol_latch_R8: assert property (@(posedge clk) disable iff (rst)
    wp_violation |=> viol_flag);

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (viol_flag && !reg_wr) |=> viol_flag);

  assert_io_fixed_R9: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && cpu_addr[15:8] == 8'hFF) |-> (mb_cs && phys_page == TOP_PG && !wp_violation));
endmodule

bind task_page_mmu mmu_checker #(.PAGE_W(PAGE_W), .MB_BASE(MB_BASE), .MB_PAGES(MB_PAGES)) u_chk (
  .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_rw(cpu_rw), .cpu_addr(cpu_addr),
  .phys_page(phys_page), .local_cs(local_cs), .mb_cs(mb_cs), .mb_read(mb_read),
  .local_write(local_write), .viol_flag(viol_flag), .wp_violation(wp_violation),
  .reg_wr(reg_wr)
);

// File: tb/test_task_page_mmu.sv
`timescale 1ns/1ps
module test_task_page_mmu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_valid = 1'b0;
  logic        cpu_rw = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        reg_sel;
  logic [13:0] phys_page;
  logic        local_cs, mb_cs, mb_read, local_write, irq;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  task_page_mmu i_task_page_mmu (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_rw(cpu_rw), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .reg_sel(reg_sel), .phys_page(phys_page),
    .local_cs(local_cs), .mb_cs(mb_cs), .mb_read(mb_read), .local_write(local_write), .irq(irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive an access at the falling edge and let it settle
  task automatic drive(input logic [15:0] a, input logic rw, input logic [7:0] d);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_rw = rw; cpu_addr = a; cpu_wdata = d;
    #1;
  endtask

  task automatic release_bus();
    @(posedge clk);
    @(negedge clk);
    cpu_valid = 1'b0; cpu_rw = 1'b1;
    #1;
  endtask

  task automatic wr_reg(input logic [7:0] off, input logic [7:0] d);
    drive({8'hFF, off}, 1'b0, d);
    release_bus();
  endtask

  task automatic rd_reg(input string req, input logic [7:0] off, input int exp);
    drive({8'hFF, off}, 1'b1, 8'h00);
    chk(req, "reg_sel", int'(reg_sel), 1);
    chk(req, $sformatf("rdata[%0h]", off), int'(cpu_rdata), exp);
    release_bus();
  endtask

  task automatic t_reset();
    chk("R1", "irq", int'(irq), 0);
    rd_reg("R1", 8'h40, 0);
    rd_reg("R1", 8'h41, 0);
    rd_reg("R1", 8'h42, 0);
    rd_reg("R1", 8'h43, 0);
    rd_reg("R1", 8'h5A, 8'h3D);
    rd_reg("R1", 8'h5B, 8'h00);
  endtask

  task automatic t_default_map();
    for (int s = 0; s < 8; s++) begin
      drive(16'((s << 13) | 16'h0123), 1'b1, 8'h00);
      chk("R1 R2", $sformatf("phys slot%0d", s), int'(phys_page), 8'h38 + s);
      chk("R5", "mb_cs", int'(mb_cs), 1);
      chk("R5", "local_cs", int'(local_cs), 0);
      release_bus();
    end
    chk("R5", "idle mb_cs", int'(mb_cs), 0);
    chk("R5", "idle local_cs", int'(local_cs), 0);
  endtask

  task automatic t_program();
    wr_reg(8'h41, 8'h03);
    rd_reg("R11", 8'h41, 3);
    wr_reg(8'h54, 8'hA5);
    wr_reg(8'h55, 8'h2B);
    rd_reg("R3", 8'h54, 8'hA5);
    rd_reg("R3", 8'h55, 8'h2B);
    wr_reg(8'h58, 8'h00);
    wr_reg(8'h59, 8'h81);
    rd_reg("R3", 8'h59, 8'h81);
    // Readonly local page in slot 6, readonly motherboard page in slot 1
    wr_reg(8'h5C, 8'h10);
    wr_reg(8'h5D, 8'h40);
    wr_reg(8'h52, 8'h3C);
    wr_reg(8'h53, 8'h40);
    // Slot 7 local readonly page for the common-page test
    wr_reg(8'h5E, 8'h77);
    wr_reg(8'h5F, 8'h40);
  endtask

  task automatic t_task_switch();
    wr_reg(8'h40, 8'hFF);
    rd_reg("R4", 8'h40, 8'h1F);
    wr_reg(8'h40, 8'h03);
    rd_reg("R4", 8'h40, 3);
    drive(16'h4567, 1'b1, 8'h00);
    chk("R2 R4", "phys task3", int'(phys_page), 16'h2BA5);
    chk("R5", "local_cs", int'(local_cs), 1);
    chk("R5", "mb_cs", int'(mb_cs), 0);
    release_bus();
    wr_reg(8'h40, 8'h00);
    drive(16'h4567, 1'b1, 8'h00);
    chk("R4", "phys task0", int'(phys_page), 8'h3A);
    release_bus();
  endtask

  task automatic t_write_paths();
    wr_reg(8'h40, 8'h03);
    drive(16'h4000, 1'b0, 8'h55);
    chk("R6", "local_write", int'(local_write), 1);
    chk("R6", "mb_read", int'(mb_read), 1);
    release_bus();
    wr_reg(8'h40, 8'h00);
    drive(16'h4000, 1'b0, 8'h55);
    chk("R6", "mb write local_write", int'(local_write), 0);
    chk("R6", "mb write mb_read", int'(mb_read), 0);
    chk("R6", "mb write mb_cs", int'(mb_cs), 1);
    release_bus();
  endtask

  task automatic t_readonly();
    wr_reg(8'h40, 8'h03);
    drive(16'hC010, 1'b0, 8'h11);
    chk("R7", "ro local_write", int'(local_write), 0);
    chk("R7", "ro mb_read", int'(mb_read), 1);
    chk("R7", "ro local_cs", int'(local_cs), 1);
    release_bus();
    drive(16'hC010, 1'b1, 8'h00);
    chk("R7", "ro read phys", int'(phys_page), 16'h0010);
    chk("R7", "ro read local_cs", int'(local_cs), 1);
    release_bus();
    drive(16'h2000, 1'b0, 8'h22);
    chk("R7", "ro mb page mb_read", int'(mb_read), 1);
    chk("R7", "ro mb page mb_cs", int'(mb_cs), 1);
    release_bus();
  endtask

  task automatic t_irq();
    wr_reg(8'h43, 8'h01);
    rd_reg("R8", 8'h43, 0);
    wr_reg(8'h42, 8'h02);
    rd_reg("R11", 8'h42, 2);
    drive(16'hC000, 1'b1, 8'h00);
    release_bus();
    chk("R8", "irq after ro read", int'(irq), 0);
    rd_reg("R8", 8'h43, 0);
    drive(16'hC000, 1'b0, 8'h00);
    release_bus();
    chk("R8", "irq after ro write", int'(irq), 1);
    rd_reg("R8", 8'h43, 1);
    wr_reg(8'h43, 8'h00);
    chk("R8", "irq after zero write", int'(irq), 1);
    wr_reg(8'h43, 8'h01);
    chk("R8", "irq after clear", int'(irq), 0);
    rd_reg("R8", 8'h43, 0);
    wr_reg(8'h42, 8'h00);
    drive(16'hC000, 1'b0, 8'h00);
    release_bus();
    chk("R8", "irq disabled", int'(irq), 0);
    rd_reg("R8", 8'h43, 1);
    wr_reg(8'h43, 8'h01);
  endtask

  task automatic t_io_page();
    drive(16'hFF10, 1'b1, 8'h00);
    chk("R9", "io phys", int'(phys_page), 8'h3F);
    chk("R9", "io mb_cs", int'(mb_cs), 1);
    release_bus();
    drive(16'hFF10, 1'b0, 8'h00);
    chk("R9", "io write mb_read", int'(mb_read), 0);
    release_bus();
  endtask

  task automatic t_common();
    drive(16'hFE20, 1'b1, 8'h00);
    chk("R10", "common off phys", int'(phys_page), 8'h77);
    chk("R10", "common off local_cs", int'(local_cs), 1);
    release_bus();
    drive(16'hFE20, 1'b0, 8'h00);
    chk("R10", "common off ro write", int'(local_write), 0);
    release_bus();
    wr_reg(8'h43, 8'h01);
    wr_reg(8'h42, 8'h01);
    rd_reg("R11", 8'h42, 1);
    drive(16'hFE20, 1'b1, 8'h00);
    chk("R10", "common on phys", int'(phys_page), 8'h3F);
    chk("R10", "common on mb_cs", int'(mb_cs), 1);
    release_bus();
    drive(16'hFE20, 1'b0, 8'h00);
    chk("R10", "common on mb_read", int'(mb_read), 0);
    release_bus();
    rd_reg("R10", 8'h43, 0);
    drive(16'hFD00, 1'b1, 8'h00);
    chk("R10", "slot7 outside common", int'(phys_page), 8'h77);
    release_bus();
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_default_map();
    t_program();
    t_task_switch();
    t_write_paths();
    t_readonly();
    t_irq();
    t_io_page();
    t_common();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule